// File: doc/BRIEF.md
# Circuit Emulation Transmit Packetizer

This block turns the byte stream of a high-order synchronous container into pseudowire packets. It gathers a fixed number of payload bytes (783 by default, so a 2349-byte container of 9 rows by 261 columns yields exactly three packets). It then emits a 4-byte emulation control word, an optional 12-byte RTP header, and the gathered payload, as one framed byte stream with start and end markers.

The control word carries two alarm bits. One reports a failure on the attachment circuit and the other reports lost packet synchronization. It also carries a length field that is nonzero only for short packets, and a 16-bit sequence number that starts from a seed and steps once per packet. A downstream stage pushes the labels.

Payload is held in a single segment buffer. While a packet drains through the output handshake, intake is blocked. Any byte offered during that time is dropped and recorded in a sticky overflow flag.

Top module: `cep_tx_packetizer`

## Requirements
- R1: Each packet is the header bytes followed by exactly PAYLOAD_BYTES payload bytes, in arrival order. `out_sop` marks the first header byte and `out_eop` the last payload byte. With the default 783, a 2349-byte container yields three packets.
- R2: Byte 0 of the control word is {4'b0, ais, rdi, neg, pos}. Bit 3 (ais) equals `ac_fail` as sampled on the first payload byte accepted for that packet, and later changes of `ac_fail` do not alter it.
- R3: Bit 2 of byte 0 (rdi) equals `sync_lost` as sampled on the first payload byte of the packet.
- R4: The neg and pos bits (byte 0, bits 1:0), the upper four bits of byte 0, and the two fragment bits (byte 1, bits 7:6) are always 0.
- R5: Byte 1, bits 5:0, hold the total packet length: 4, plus 12 when RTP is on, plus the payload length. The field holds this total when it is below 64 and holds 0 otherwise. With a 48-byte payload, the field is 52 without RTP and 0 with RTP.
- R6: Bytes 2 and 3 carry the sequence number, big-endian. The first packet after reset carries `seq_seed` as held during reset. Each later packet carries the previous value plus one, modulo 65536.
- R7: When `rtp_en` is 1 on the first payload byte, 12 RTP bytes follow the control word. RTP bytes 2 and 3 (packet bytes 6 and 7) repeat the sequence number, and all other RTP bytes are 0.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data`, `out_sop` and `out_eop` hold their values.
- R9: An input byte offered while a finished segment is still draining sets `overflow`, which stays 1 until reset. The byte is dropped and does not appear in any packet.
- R10: An input byte with `in_sof` = 1 starts a new segment. Bytes of an unfinished segment collected before it are discarded.
- R11: During and right after reset, `out_valid` and `overflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_seed | input | 16 | Initial sequence number, loaded during reset |
| rtp_en | input | 1 | Adds the RTP header to the packet being started |
| ac_fail | input | 1 | Attachment-circuit failure indication |
| sync_lost | input | 1 | Loss of packet synchronization indication |
| in_valid | input | 1 | Input byte present |
| in_sof | input | 1 | Input byte is the first of a container |
| in_data | input | 8 | Input container byte |
| out_ready | input | 1 | Downstream accepts the current byte |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Output packet byte |
| out_sop | output | 1 | First byte of a packet |
| out_eop | output | 1 | Last byte of a packet |
| overflow | output | 1 | Sticky input-dropped flag |

## Verification
The packet header becomes visible in the cycle after the last payload byte is written, because that write moves the state register to the header phase. Each output byte then advances one cycle after it is accepted. The overflow flag rises one cycle after the offending byte.

The bench drives inputs and samples outputs on falling edges, so every result is read half a period after the rising edge that produced it. It compares each accepted byte with a value computed from the seed, the flags driven on the first payload byte, and the payload pattern. It reads the overflow flag at the first falling edge after the dropped byte.

// File: rtl/cep_tx_pkg.sv
package cep_tx_pkg;

    localparam int unsigned CW_BYTES      = 4;
    localparam int unsigned RTP_BYTES     = 12;
    localparam int unsigned SHORT_LIMIT   = 64;

    typedef enum logic [1:0] {
        ST_FILL = 2'd0,
        ST_HDR  = 2'd1,
        ST_PAY  = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic ais;
        logic rdi;
        logic rtp;
    } pkt_ctl_t;

    function automatic logic [5:0] short_len(int unsigned payload, logic rtp);
        int unsigned total;
        total = CW_BYTES + (rtp ? RTP_BYTES : 0) + payload;
        return (total < SHORT_LIMIT) ? 6'(total) : 6'd0;
    endfunction

    // Header byte at position idx: control word, then optional RTP header.
    function automatic logic [7:0] hdr_byte(logic [4:0] idx, pkt_ctl_t c,
                                            logic [5:0] len, logic [15:0] seq);
        logic [7:0] b;
        case (idx)
            5'd0:       b = {4'b0000, c.ais, c.rdi, 2'b00};
            5'd1:       b = {2'b00, len};
            5'd2, 5'd6: b = seq[15:8];
            5'd3, 5'd7: b = seq[7:0];
            default:    b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/cep_seq_ctr.sv
module cep_seq_ctr #(
    parameter int unsigned SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEQ_W-1:0] seed,
    input  logic             step,
    output logic [SEQ_W-1:0] seq
);

    always_ff @(posedge clk) begin
        if (rst)       seq <= seed;
        else if (step) seq <= seq + SEQ_W'(1);
    end

    // R6: one increment per packet, modulo wrap
    p_seq_step_r6: assert property (@(posedge clk) disable iff (rst)
        step |=> seq == $past(seq) + SEQ_W'(1));

    p_seq_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(seq));

endmodule

// File: rtl/cep_payload_buf.sv
module cep_payload_buf #(
    parameter int unsigned DEPTH = 783,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          wr_sof,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          seg_first,
    output logic          seg_done
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] wr_addr;

    // A container start realigns the segment to offset zero (R10).
    always_comb begin
        wr_addr   = wr_sof ? '0 : wr_ptr;
        seg_first = wr_en && (wr_addr == '0);
        seg_done  = wr_en && (wr_addr == LAST);
        rd_data   = mem[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst)        wr_ptr <= '0;
        else if (wr_en) wr_ptr <= seg_done ? '0 : wr_addr + AW'(1);
    end

    // R1: the write pointer never leaves the segment
    p_ptr_range_r1: assert property (@(posedge clk) disable iff (rst)
        wr_ptr <= LAST);

    p_done_wraps_r1: assert property (@(posedge clk) disable iff (rst)
        seg_done |=> wr_ptr == '0);

endmodule

// File: rtl/cep_tx_packetizer.sv
module cep_tx_packetizer
    import cep_tx_pkg::*;
#(
    parameter int unsigned PAYLOAD_BYTES = 783,
    parameter int unsigned SEQ_W         = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEQ_W-1:0] seq_seed,
    input  logic             rtp_en,
    input  logic             ac_fail,
    input  logic             sync_lost,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic [7:0]       in_data,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_sop,
    output logic             out_eop,
    output logic             overflow
);

    localparam int unsigned  AW       = $clog2(PAYLOAD_BYTES);
    localparam logic [AW-1:0] PAY_LAST = AW'(PAYLOAD_BYTES - 1);
    localparam logic [4:0]   HDR_LAST_CW  = 5'(CW_BYTES - 1);
    localparam logic [4:0]   HDR_LAST_RTP = 5'(CW_BYTES + RTP_BYTES - 1);

    tx_state_e     state;
    pkt_ctl_t      ctl_q;
    logic [AW-1:0] rd_ptr;
    logic [4:0]    hdr_idx;
    logic [SEQ_W-1:0] seq;
    logic [7:0]    pay_byte;
    logic          wr_en, seg_first, seg_done, fire, hdr_last;
    logic [5:0]    len_fld;

    assign wr_en = in_valid && (state == ST_FILL);

    cep_payload_buf #(.DEPTH(PAYLOAD_BYTES)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sof    (in_sof),
        .wr_data   (in_data),
        .rd_addr   (rd_ptr),
        .rd_data   (pay_byte),
        .seg_first (seg_first),
        .seg_done  (seg_done)
    );

    cep_seq_ctr #(.SEQ_W(SEQ_W)) u_seq (
        .clk  (clk),
        .rst  (rst),
        .seed (seq_seed),
        .step (fire && out_eop),
        .seq  (seq)
    );

    always_comb begin
        len_fld   = short_len(PAYLOAD_BYTES, ctl_q.rtp);
        hdr_last  = (hdr_idx == (ctl_q.rtp ? HDR_LAST_RTP : HDR_LAST_CW));
        out_valid = (state != ST_FILL);
        out_sop   = (state == ST_HDR) && (hdr_idx == '0);
        out_eop   = (state == ST_PAY) && (rd_ptr == PAY_LAST);
        out_data  = (state == ST_HDR) ? hdr_byte(hdr_idx, ctl_q, len_fld, seq[15:0])
                                      : pay_byte;
        fire      = out_valid && out_ready;
    end

    // Flags and header option are captured once, on the first payload byte.
    always_ff @(posedge clk) begin
        if (rst)            ctl_q <= '0;
        else if (seg_first) ctl_q <= '{ais: ac_fail, rdi: sync_lost, rtp: rtp_en};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_FILL;
            hdr_idx <= '0;
            rd_ptr  <= '0;
        end else begin
            case (state)
                ST_FILL: if (seg_done) begin
                    state   <= ST_HDR;
                    hdr_idx <= '0;
                    rd_ptr  <= '0;
                end
                ST_HDR: if (fire) begin
                    if (hdr_last) state   <= ST_PAY;
                    else          hdr_idx <= hdr_idx + 5'd1;
                end
                ST_PAY: if (fire) begin
                    if (rd_ptr == PAY_LAST) state  <= ST_FILL;
                    else                    rd_ptr <= rd_ptr + AW'(1);
                end
                default: state <= ST_FILL;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                                 overflow <= 1'b0;
        else if (in_valid && state != ST_FILL)   overflow <= 1'b1;
    end

    // R8: a stalled byte stays put
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
                                    && $stable(out_sop) && $stable(out_eop));

    // R9: overflow rises after a byte offered during drain, then sticks
    p_ovf_set_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid && out_valid |=> overflow);

    p_no_overflow_clear_r9: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    // R1: framing markers are exclusive and only on valid bytes
    p_frame_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_sop, out_eop}) && (!(out_sop || out_eop) || out_valid));

    // R2/R3: captured flags stay frozen while a packet is on the output
    p_ctl_held_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(out_valid) |-> $stable(ctl_q));

    // R11: reset clears output and flag
    p_reset_r11: assert property (@(posedge clk)
        rst |=> !out_valid && !overflow);

endmodule

// File: tb/cep_tx_packetizer_tb.sv
module cep_tx_packetizer_tb_top;

    localparam int BIG   = 783;
    localparam int SMALL = 48;
    localparam logic [15:0] SEED_BIG   = 16'hFFFE;
    localparam logic [15:0] SEED_SMALL = 16'h7A31;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst, rtp_en, ac_fail, sync_lost, in_sof, out_ready;
    logic [7:0] in_data;
    logic       vb, vs;
    logic       b_valid, b_sop, b_eop, b_ovf, s_valid, s_sop, s_eop, s_ovf;
    logic [7:0] b_data, s_data;

    cep_tx_packetizer dut_i (
        .clk(clk), .rst(rst), .seq_seed(SEED_BIG), .rtp_en(rtp_en),
        .ac_fail(ac_fail), .sync_lost(sync_lost), .in_valid(vb), .in_sof(in_sof),
        .in_data(in_data), .out_ready(out_ready), .out_valid(b_valid),
        .out_data(b_data), .out_sop(b_sop), .out_eop(b_eop), .overflow(b_ovf));

    cep_tx_packetizer #(.PAYLOAD_BYTES(SMALL)) dut_small_i (
        .clk(clk), .rst(rst), .seq_seed(SEED_SMALL), .rtp_en(rtp_en),
        .ac_fail(ac_fail), .sync_lost(sync_lost), .in_valid(vs), .in_sof(in_sof),
        .in_data(in_data), .out_ready(out_ready), .out_valid(s_valid),
        .out_data(s_data), .out_sop(s_sop), .out_eop(s_eop), .overflow(s_ovf));

    int sel;
    logic       o_valid, o_sop, o_eop, o_ovf;
    logic [7:0] o_data;
    always_comb begin
        o_valid = sel ? s_valid : b_valid;
        o_sop   = sel ? s_sop   : b_sop;
        o_eop   = sel ? s_eop   : b_eop;
        o_ovf   = sel ? s_ovf   : b_ovf;
        o_data  = sel ? s_data  : b_data;
    end

    int checks = 0;
    int fails  = 0;
    int exp_seq [2];
    bit done = 0;

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int len_exp(int payload, bit rtp);
        int total = 4 + (rtp ? 12 : 0) + payload;
        return (total < 64) ? total : 0;
    endfunction

    function automatic logic [7:0] hdr_exp(int idx, bit l, bit r, int len, int seq);
        case (idx)
            0:    return {4'b0, l, r, 2'b00};
            1:    return {2'b00, 6'(len)};
            2, 6: return 8'(seq >> 8);
            3, 7: return 8'(seq);
            default: return 8'h00;
        endcase
    endfunction

    task automatic feed(int n, logic [7:0] base, bit sof0, bit l, bit r, bit rtp);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_data = base + 8'(k);
            in_sof  = sof0 && (k == 0);
            if (k == 0) begin ac_fail = l; sync_lost = r; rtp_en = rtp; end
            else if (k == 1) begin ac_fail = ~l; sync_lost = ~r; rtp_en = ~rtp; end
            if (sel == 0) vb = 1'b1; else vs = 1'b1;
        end
        @(negedge clk);
        vb = 1'b0; vs = 1'b0; in_sof = 1'b0;
    endtask

    task automatic drain(int payload, logic [7:0] base, bit l, bit r, bit rtp);
        int hlen  = rtp ? 16 : 4;
        int total = hlen + payload;
        int seq   = exp_seq[sel];
        int len   = len_exp(payload, rtp);
        int got   = 0;
        int idle  = 0;
        bit held  = 0;
        logic [7:0] hd; logic hs, he;
        logic [7:0] exp_b;
        string req;
        while (got < total) begin
            out_ready = ($urandom_range(0, 3) != 0);
            if (held) begin
                check(o_valid && o_data == hd && o_sop == hs && o_eop == he,
                      "R8", "stall hold", int'(o_data), int'(hd));
                held = 0;
            end
            if (o_valid) begin
                idle = 0;
                if (!out_ready) begin
                    held = 1; hd = o_data; hs = o_sop; he = o_eop;
                end else begin
                    if (got < hlen) exp_b = hdr_exp(got, l, r, len, seq);
                    else            exp_b = base + 8'(got - hlen);
                    if (got == 0)        req = "R2/R3/R4";
                    else if (got == 1)   req = "R4/R5";
                    else if (got < 4)    req = "R6";
                    else if (got < hlen) req = "R7";
                    else                 req = "R1";
                    check(o_data == exp_b, req, $sformatf("byte %0d", got),
                          int'(o_data), int'(exp_b));
                    if (got == 0 || got == total - 1)
                        check(o_sop == (got == 0) && o_eop == (got == total - 1),
                              "R1", "sop/eop", {o_sop, o_eop},
                              {got == 0, got == total - 1});
                    got++;
                end
            end else begin
                idle++;
                if (idle > 50) begin
                    check(0, "R1", "packet missing", got, total);
                    break;
                end
            end
            @(negedge clk);
        end
        out_ready = 1'b0;
        exp_seq[sel] = (seq + 1) & 16'hFFFF;
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        check(0, "R1", "watchdog expired", 0, 1);
        report();
    end

    initial begin
        logic [7:0] b, b2;
        bit l, r, p;
        void'($urandom(32'h5EED_0C3F));
        rst = 1; vb = 0; vs = 0; in_sof = 0; in_data = 0; out_ready = 0;
        rtp_en = 0; ac_fail = 0; sync_lost = 0; sel = 0;
        exp_seq[0] = SEED_BIG; exp_seq[1] = SEED_SMALL;
        repeat (3) @(negedge clk);
        check(!b_valid && !b_ovf && !s_valid && !s_ovf, "R11", "reset outputs",
              {b_valid, b_ovf, s_valid, s_ovf}, 0);
        rst = 0;
        @(negedge clk);
        check(!b_valid && !b_ovf, "R11", "after reset", {b_valid, b_ovf}, 0);

        // R1: one 2349-byte container as three packets; R6 wraps FFFE->0000
        sel = 0;
        for (int k = 0; k < 3; k++) begin
            b = 8'($urandom); l = k[0]; r = (k == 1);
            feed(BIG, b, k == 0, l, r, 0);
            drain(BIG, b, l, r, 0);
        end
        check(exp_seq[0] == 16'h0001, "R6", "wrap count", exp_seq[0], 16'h0001);
        // R7 on full-size packets
        for (int k = 0; k < 2; k++) begin
            b = 8'($urandom); l = $urandom_range(0, 1); r = $urandom_range(0, 1);
            feed(BIG, b, 0, l, r, 1);
            drain(BIG, b, l, r, 1);
        end

        // R5 boundary: 52 without RTP, 64 -> 0 with RTP
        sel = 1;
        b = 8'($urandom); feed(SMALL, b, 1, 0, 1, 0); drain(SMALL, b, 0, 1, 0);
        b = 8'($urandom); feed(SMALL, b, 0, 1, 0, 1); drain(SMALL, b, 1, 0, 1);
        for (int k = 0; k < 6; k++) begin
            b = 8'($urandom); l = $urandom_range(0, 1);
            r = $urandom_range(0, 1); p = $urandom_range(0, 1);
            feed(SMALL, b, 0, l, r, p);
            drain(SMALL, b, l, r, p);
        end

        // R10: partial segment discarded by a new container start
        b = 8'($urandom); b2 = b + 8'h80;
        feed(10, b, 1, 1, 1, 1);
        feed(SMALL, b2, 1, 0, 1, 0);
        drain(SMALL, b2, 0, 1, 0);

        // R9: byte offered while draining is dropped and flagged
        check(!s_ovf && !b_ovf, "R9", "no overflow yet", {s_ovf, b_ovf}, 0);
        b = 8'($urandom);
        feed(SMALL, b, 0, 1, 1, 0);
        vs = 1'b1; in_data = 8'hEE;
        @(negedge clk);
        vs = 1'b0;
        check(s_ovf == 1'b1, "R9", "overflow set", s_ovf, 1);
        check(b_ovf == 1'b0, "R9", "other unit clean", b_ovf, 0);
        drain(SMALL, b, 1, 1, 0);
        repeat (3) @(negedge clk);
        check(s_ovf == 1'b1, "R9", "overflow sticky", s_ovf, 1);
        check(!s_valid, "R9", "dropped byte not packetized", s_valid, 0);

        report();
    end

endmodule